// File: doc/BRIEF.md
# Relay Coil Peak-and-Hold Gate Driver

This block produces the gate signal for a low-side switch in series with a relay coil. When the engage input rises, the gate is held solidly on for a pull-in time so the armature closes against its spring. The block then drops to a fixed-frequency PWM hold phase. Because the hold current only has to keep a closed armature in place, coil dissipation falls sharply in that phase.

The hold duty is not a fixed number. Supply-voltage samples arrive on a valid/ready stream. For each accepted sample a sequential divider works out the fraction of a PWM period that gives the configured average (target) coil voltage. The result is clamped between a minimum on-time and the full period. The new duty reaches the gate only at the start of a PWM period. A zero sample is treated as unusable and selects full drive.

The sample stream applies back-pressure. `vsup_ready` is low while a quotient is being formed. A source that finds ready low must keep `vsup_valid` and `vsup_data` steady until a clock edge at which ready is high. A sample is taken only on an edge where both valid and ready are high.

Top module: `coil_hold_pwm`

## Requirements
- R1: From idle with engage high, the phase goes to pull-in (code 2'b01) on the next edge. The gate is then high without a break for exactly `cfg_pull_ticks` × TICK_DIV clocks, after which the phase becomes hold (code 2'b10).
- R2: A `cfg_pull_ticks` value of zero gives a pull-in of one tick, which is TICK_DIV clocks.
- R3: In hold, the gate repeats with a period of `cfg_period` clocks, with values below 2 acting as 2. Each period starts with the gate high for the latched duty count, and the gate is low for the rest of the period. Phase code 2'b11 never appears.
- R4: For a nonzero sample S, the duty count is floor(`cfg_target` × P / S), where P is the effective period. The count is raised to `cfg_min_on` if it is below that value, and then lowered to P if it is above P.
- R5: A zero supply sample sets the duty to full drive, so the gate stays high for the whole hold phase.
- R6: After a sample is accepted, `vsup_ready` stays low for VW+PW clocks. The new duty becomes active at the edge that ends that interval. A valid sample that is held while ready is low is accepted only once ready returns high.
- R7: A new duty or period takes effect only at a PWM period boundary. The first boundary is the entry into hold.
- R8: While engage is low the gate is low in the same cycle, whatever the phase. The phase reads idle (2'b00) from the next edge on. Raising engage again always restarts a full pull-in.
- R9: During and after reset the gate is low, the phase is idle, `vsup_ready` is high, and the duty is full drive until a first sample has been converted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| engage | input | 1 | Request to energise the coil |
| vsup_valid | input | 1 | Supply sample offered |
| vsup_ready | output | 1 | Sample can be taken this edge |
| vsup_data | input | VW | Supply-voltage sample, 0 = unusable |
| cfg_pull_ticks | input | PULL_W | Pull-in length in ticks of TICK_DIV clocks |
| cfg_period | input | PW | PWM period in clocks |
| cfg_target | input | VW | Target average coil voltage, same scale as samples |
| cfg_min_on | input | PW | Lowest allowed hold on-count |
| gate | output | 1 | Gate drive to the low-side switch |
| phase | output | 2 | 00 idle, 01 pull-in, 10 hold |

## Verification
The hardest situation to reach is a duty update that lands in the middle of a hold period. In that case the old on-count must finish out its period, and the new one must start exactly at the following boundary. The stimulus offers new samples while the relay sits in hold, including two samples offered back to back with valid kept high, so that the quotients complete at arbitrary points in the PWM count. Short drops of engage, lasting a single clock, are placed inside pull-in and inside hold. These check the immediate release of the gate and the full restart of pull-in. A reference model tracks elapsed pull-in time, position within the period, and divider latency, and it is compared against the gate, phase and ready outputs on every clock.

// File: rtl/coil_hold_pkg.sv
package coil_hold_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_PULL = 2'b01,
    PH_HOLD = 2'b10
  } coil_phase_e;
endpackage

// File: rtl/coil_pull_timer.sv
// Measures the pull-in interval: limit ticks of TICK_DIV clocks each.
module coil_pull_timer #(
  parameter int TICK_DIV = 250000,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] ticks;
  logic [CW-1:0] lim_eff;
  logic          tick_end;

  assign lim_eff = (limit == '0) ? CW'(1) : limit;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam int PSW = $clog2(TICK_DIV);
      logic [PSW-1:0] pre;
      assign tick_end = (pre == PSW'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre <= '0;
        else if (!run)     pre <= '0;
        else if (tick_end) pre <= '0;
        else               pre <= pre + PSW'(1);
      end
    end else begin : g_direct
      assign tick_end = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ticks <= '0;
    else if (!run)     ticks <= '0;
    else if (tick_end) ticks <= ticks + CW'(1);
  end

  assign done = run && tick_end && (ticks == lim_eff - CW'(1));
endmodule

// File: rtl/coil_duty_div.sv
// Sequential restoring divider: duty = clamp(target*period / sample).
module coil_duty_div #(
  parameter int VW = 12,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [VW-1:0] s_data,
  input  logic [VW-1:0] target,
  input  logic [PW-1:0] period_eff,
  input  logic [PW-1:0] min_on,
  output logic [PW-1:0] duty
);
  localparam int NW = VW + PW;
  localparam int CNW = $clog2(NW);

  logic           busy;
  logic [CNW-1:0] step;
  logic [VW-1:0]  den;
  logic [VW-1:0]  rem;
  logic [NW-1:0]  quo;
  logic [PW-1:0]  cap_per;
  logic [PW-1:0]  cap_min;
  logic           cap_zero;

  logic [VW:0]    shifted;
  logic           ge;
  logic [VW-1:0]  rem_nx;
  logic [NW-1:0]  q_fin;
  logic [NW-1:0]  q_lo;
  logic [PW-1:0]  q_res;

  assign s_ready = !busy;
  assign shifted = {rem, quo[NW-1]};
  assign ge      = (shifted >= {1'b0, den});
  assign rem_nx  = ge ? VW'(shifted - {1'b0, den}) : VW'(shifted);
  assign q_fin   = {quo[NW-2:0], ge};
  assign q_lo    = (q_fin < NW'(cap_min)) ? NW'(cap_min) : q_fin;
  assign q_res   = (q_lo > NW'(cap_per)) ? cap_per : PW'(q_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      den      <= '0;
      rem      <= '0;
      quo      <= '0;
      cap_per  <= '0;
      cap_min  <= '0;
      cap_zero <= 1'b0;
      duty     <= '1;
    end else if (busy) begin
      rem  <= rem_nx;
      quo  <= q_fin;
      step <= step + CNW'(1);
      if (step == CNW'(NW - 1)) begin
        busy <= 1'b0;
        duty <= cap_zero ? '1 : q_res;
      end
    end else if (s_valid) begin
      busy     <= 1'b1;
      step     <= '0;
      den      <= s_data;
      rem      <= '0;
      quo      <= NW'(target) * NW'(period_eff);
      cap_per  <= period_eff;
      cap_min  <= min_on;
      cap_zero <= (s_data == '0);
    end
  end
endmodule

// File: rtl/coil_pwm_gen.sv
// Fixed-period PWM; duty and period latch only at period boundaries.
module coil_pwm_gen #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period_eff,
  input  logic [PW-1:0] duty,
  output logic          on,
  output logic [PW-1:0] cnt,
  output logic [PW-1:0] duty_sh
);
  logic [PW-1:0] per_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      duty_sh <= '1;
      per_sh  <= PW'(2);
    end else if (!run || (cnt == per_sh - PW'(1))) begin
      cnt     <= '0;
      duty_sh <= duty;
      per_sh  <= period_eff;
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  assign on = run && (cnt < duty_sh);
endmodule

// File: rtl/coil_hold_pwm.sv
module coil_hold_pwm
  import coil_hold_pkg::*;
#(
  parameter int TICK_DIV = 250000,
  parameter int PULL_W   = 9,
  parameter int VW       = 12,
  parameter int PW       = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              engage,
  input  logic              vsup_valid,
  output logic              vsup_ready,
  input  logic [VW-1:0]     vsup_data,
  input  logic [PULL_W-1:0] cfg_pull_ticks,
  input  logic [PW-1:0]     cfg_period,
  input  logic [VW-1:0]     cfg_target,
  input  logic [PW-1:0]     cfg_min_on,
  output logic              gate,
  output logic [1:0]        phase
);
  coil_phase_e   state;
  logic [PW-1:0] per_eff;
  logic          pull_done;
  logic [PW-1:0] duty_live;
  logic          pwm_on;
  logic [PW-1:0] pwm_cnt;
  logic [PW-1:0] pwm_duty;

  assign per_eff = (cfg_period < PW'(2)) ? PW'(2) : cfg_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= PH_IDLE;
    else if (!engage) state <= PH_IDLE;
    else begin
      case (state)
        PH_IDLE: state <= PH_PULL;
        PH_PULL: if (pull_done) state <= PH_HOLD;
        default: state <= PH_HOLD;
      endcase
    end
  end

  coil_pull_timer #(.TICK_DIV(TICK_DIV), .CW(PULL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == PH_PULL),
    .limit (cfg_pull_ticks),
    .done  (pull_done)
  );

  coil_duty_div #(.VW(VW), .PW(PW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (vsup_valid),
    .s_ready    (vsup_ready),
    .s_data     (vsup_data),
    .target     (cfg_target),
    .period_eff (per_eff),
    .min_on     (cfg_min_on),
    .duty       (duty_live)
  );

  coil_pwm_gen #(.PW(PW)) u_pwm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (state == PH_HOLD),
    .period_eff (per_eff),
    .duty       (duty_live),
    .on         (pwm_on),
    .cnt        (pwm_cnt),
    .duty_sh    (pwm_duty)
  );

  assign gate  = engage && ((state == PH_PULL) || ((state == PH_HOLD) && pwm_on));
  assign phase = state;
endmodule

// File: rtl/coil_hold_pwm_chk.sv
module coil_hold_pwm_chk #(
  parameter int PW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          engage,
  input logic          gate,
  input logic [1:0]    phase,
  input logic          vsup_valid,
  input logic          vsup_ready,
  input logic [PW-1:0] pwm_cnt,
  input logic [PW-1:0] pwm_duty
);
  assert_gate_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !engage |-> !gate);

  assert_idle_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !engage |=> (phase == 2'b00));

  assert_idle_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00) |-> !gate);

  assert_pullin_solid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (engage && phase == 2'b01) |-> gate);

  assert_hold_via_pullin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && $past(phase) != 2'b10) |-> ($past(phase) == 2'b01));

  assert_phase_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11);

  assert_duty_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && $past(phase) == 2'b10 && pwm_cnt != '0) |-> $stable(pwm_duty));

  assert_accept_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_valid && vsup_ready) |=> !vsup_ready);
endmodule

bind coil_hold_pwm coil_hold_pwm_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .engage     (engage),
  .gate       (gate),
  .phase      (phase),
  .vsup_valid (vsup_valid),
  .vsup_ready (vsup_ready),
  .pwm_cnt    (pwm_cnt),
  .pwm_duty   (pwm_duty)
);

// File: tb/coil_hold_pwm_tb.sv
module coil_hold_pwm_tb;
  localparam int TD  = 4;
  localparam int PLW = 9;
  localparam int VW  = 12;
  localparam int PW  = 14;
  localparam int NW  = VW + PW;
  localparam int FULL = (1 << PW) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic engage = 0;
  logic vsup_valid = 0;
  logic vsup_ready;
  logic [VW-1:0] vsup_data = '0;
  logic [PLW-1:0] cfg_pull_ticks = 9'd3;
  logic [PW-1:0] cfg_period = 14'd20;
  logic [VW-1:0] cfg_target = 12'd1200;
  logic [PW-1:0] cfg_min_on = 14'd2;
  logic gate;
  logic [1:0] phase;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  coil_hold_pwm #(.TICK_DIV(TD), .PULL_W(PLW), .VW(VW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .engage(engage),
    .vsup_valid(vsup_valid), .vsup_ready(vsup_ready), .vsup_data(vsup_data),
    .cfg_pull_ticks(cfg_pull_ticks), .cfg_period(cfg_period),
    .cfg_target(cfg_target), .cfg_min_on(cfg_min_on),
    .gate(gate), .phase(phase)
  );

  // Behavioural reference: 0 idle, 1 pull-in, 2 hold
  int m_state, m_elapsed, m_pos, m_on, m_len;
  int m_duty, m_pend, m_wait;
  bit m_busy;

  function automatic int eff_period(int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int quotient(int s, int t, int p, int mn);
    int q;
    if (s == 0) return FULL;
    q = (t * p) / s;
    if (q < mn) q = mn;
    if (q > p) q = p;
    return q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_elapsed = 0; m_pos = 0; m_on = FULL; m_len = 2;
      m_duty = FULL; m_pend = 0; m_wait = 0; m_busy = 0;
    end else begin
      int pe, pl;
      pe = eff_period(int'(cfg_period));
      pl = (cfg_pull_ticks == 0) ? 1 : int'(cfg_pull_ticks);
      // PWM position, using phase and duty from before this edge (R3, R7)
      if (m_state == 2 && m_pos != m_len - 1) m_pos++;
      else begin m_pos = 0; m_on = m_duty; m_len = pe; end
      // phase sequencing (R1, R2, R8)
      if (!engage) m_state = 0;
      else if (m_state == 0) begin m_state = 1; m_elapsed = 0; end
      else if (m_state == 1) begin
        if (m_elapsed == pl * TD - 1) m_state = 2;
        else m_elapsed++;
      end
      // sample conversion latency (R4, R5, R6)
      if (m_busy) begin
        m_wait++;
        if (m_wait == NW) begin m_duty = m_pend; m_busy = 0; end
      end else if (vsup_valid) begin
        m_busy = 1; m_wait = 0;
        m_pend = quotient(int'(vsup_data), int'(cfg_target), pe, int'(cfg_min_on));
      end
    end
  end

  task automatic check(string tag, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %0d expected %0d", tag, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    int eg;
    string tg;
    eg = (engage && (m_state == 1 || (m_state == 2 && m_pos < m_on))) ? 1 : 0;
    if (!rst_n)            tg = "R9";
    else if (m_state == 1) tg = "R1";
    else if (m_state == 2) tg = (m_on == FULL) ? "R5" : "R3";
    else                   tg = "R8";
    check(tg, "gate", int'(gate), eg);
    check(rst_n ? "R1" : "R9", "phase", int'(phase), m_state);
    check(rst_n ? "R6" : "R9", "ready", int'(vsup_ready), m_busy ? 0 : 1);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_sample(int d);
    @(posedge clk); #1;
    vsup_valid = 1; vsup_data = VW'(d);
    forever begin @(negedge clk); if (vsup_ready) break; end
    @(posedge clk); #1;
    vsup_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      finished = 1;
      $finish;
    end
  end

  initial begin
    // R9: reset state observed during and right after reset
    step(3);
    rst_n = 1;
    step(4);
    // R1 / R5: pull-in then full drive before any sample
    engage = 1;
    step(40);
    // R4 / R6 / R7: 1200*20/2400 = 10, lands mid-period
    send_sample(2400);
    step(80);
    // R6: two samples back to back with valid held through back-pressure
    @(posedge clk); #1;
    vsup_valid = 1; vsup_data = 12'd6000 % 4096;
    forever begin @(negedge clk); if (vsup_ready) break; end
    @(posedge clk); #1;
    vsup_data = 12'd1000;   // 24 clamps to period 20 (R4)
    forever begin @(negedge clk); if (vsup_ready) break; end
    @(posedge clk); #1;
    vsup_valid = 0;
    step(80);
    // R4: lower clamp: 24000/4095 = 5 raised to 8
    cfg_min_on = 14'd8;
    send_sample(4095);
    step(80);
    // R5: zero sample selects full drive
    send_sample(0);
    step(60);
    // R8: one-clock release in hold restarts pull-in
    send_sample(3000);
    step(40);
    engage = 0; step(1); engage = 1;
    step(60);
    // R8: release inside pull-in
    engage = 0; step(1); engage = 1;
    step(6);
    engage = 0; step(3); engage = 1;
    step(50);
    // R2: zero pull-in ticks acts as one tick
    engage = 0; cfg_pull_ticks = '0; step(2);
    engage = 1; step(30);
    // R3 / R7: period changes latch at boundaries, below 2 acts as 2
    cfg_period = 14'd7; step(30);
    send_sample(1500);
    step(60);
    cfg_period = 14'd1; step(20);
    send_sample(2000);
    step(60);
    // R4: min on-count above period is cut to period
    cfg_period = 14'd9; cfg_min_on = 14'd30;
    send_sample(4000);
    step(60);
    engage = 0; step(5);
    // R9: reset mid-hold returns everything to idle
    engage = 1; step(30);
    rst_n = 0; step(2); rst_n = 1; engage = 0; step(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule